// File: doc/BRIEF.md
# Shared Buffer Pool Backpressure Controller

This block keeps the books for a cell-buffer memory that up to sixteen transmit pools share. Four interfaces each own four pool slots. Every interface is configured to use one, two or four of its slots. An upstream scheduler reports each buffer it takes with an allocate event and each buffer it returns with a free event. Every event carries a requested pool ID and a flag that marks switched-circuit traffic. The block maps each event onto the pool that is really in use, keeps one usage counter per pool and one total counter, and drives backpressure back to the scheduler.

Per-pool limits only ration the memory. They sit below the true share because packets that are already queued upstream keep arriving after backpressure is raised, so the counters must keep counting past the limits. A separate quota over the total usage raises a global backpressure signal. Each pool and the global quota have their own hysteresis, so a signal drops only once usage has fallen well below its limit. Limits, hysteresis values and the pool split of each interface are written through a small write-only register port.

Top module: `buf_pool_bp`

## Requirements
- R1: While reset is applied, and directly after it, poolBp, globalBp and errFlag are all zero.
- R2: The backpressure bit of a pool is set when that pool's usage count is strictly greater than its limit. A count equal to the limit leaves the bit clear.
- R3: All backpressure outputs are registered. An allocate event changes a counter at the clock edge on which it is sampled, and the output follows on the next edge.
- R4: Allocations keep being counted after backpressure is raised. A pool runs at least 16 buffers past its limit without saturating or wrapping, and each counter moves by at most one per cycle.
- R5: A pool's backpressure bit is cleared only when its count is less than or equal to its limit minus its hysteresis value. Between that point and the limit, the bit keeps its previous state.
- R6: globalBp is set when the total usage over all pools exceeds the global quota, even when no pool is over its own limit. It is cleared when total usage is less than or equal to the quota minus the global hysteresis.
- R7: Values after reset: every pool limit is 494, the hysteresis is 6 for pools 0 to 3 and 40 for pools 4 to 15, the quota is 8168, the global hysteresis is 120, and every interface is in one-pool mode.
- R8: A pool ID is {interface[1:0], slot[1:0]}. The split code of interface i sits in mode register bits [2i+1:2i]. Code 00 (one pool) maps every slot to slot 0, code 01 (two pools) keeps only slot bit 0, and codes 10 and 11 (four pools) keep the slot as requested.
- R9: An event whose circuit flag is set is accounted to slot 0 of its interface, whatever slot is requested and whatever the split mode.
- R10: An allocate and a free that map to the same pool in one cycle leave that pool and the total unchanged and raise no error. When they map to different pools, both take effect.
- R11: A free that maps to a pool whose count is zero changes no counter and sets errFlag. errFlag stays set until reset.
- R12: Register map: address 0x00+p holds the limit of pool p, 0x10+p holds the hysteresis of pool p, 0x20 holds the quota, 0x21 holds the global hysteresis and 0x22 holds the mode register. A write takes effect on the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | A buffer was allocated this cycle |
| allocPool | input | 4 | Requested pool ID of the allocation |
| allocCircuit | input | 1 | Allocation belongs to switched-circuit traffic |
| freeValid | input | 1 | A buffer was freed this cycle |
| freePool | input | 4 | Requested pool ID of the free |
| freeCircuit | input | 1 | Free belongs to switched-circuit traffic |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 6 | Register address |
| regWrData | input | 18 | Register write data |
| poolBp | output | 16 | Per-pool backpressure, bit p for pool p |
| globalBp | output | 1 | Backpressure for the whole memory |
| errFlag | output | 1 | Sticky flag for a free to an empty pool |

## Verification
The checker watches a set of invariants on every cycle:
- each pool counter moves by at most one per cycle;
- the total always equals the sum of the pool counters;
- the increment and decrement strobes are each one-hot or idle;
- the error flag never clears;
- every rise of a backpressure signal follows a count above its limit;
- every fall follows a count at or below the release point.

What the invariants cannot show is left to the bench scenarios:
- that a pool or slot mapping lands on the intended pool;
- that the reset values are the intended ones;
- that the outputs lag the counter by exactly one cycle;
- the exact allocate and free counts at which the hysteresis band opens and closes.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int IFACES   = 4;
  localparam int SLOTS    = 4;
  localparam int POOLS    = IFACES * SLOTS;
  localparam int IF_W     = $clog2(IFACES);
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam int POOL_W   = IF_W + SLOT_W;
  localparam int CNT_W    = 14;
  localparam int TOT_W    = CNT_W + POOL_W;
  localparam int ADDR_W   = 6;
  localparam int DATA_W   = TOT_W;
  localparam int MODE_W   = 2 * IFACES;

  localparam int DEF_LIMIT     = 494;
  localparam int DEF_HYST_LO   = 6;
  localparam int DEF_HYST_HI   = 40;
  localparam int DEF_LO_POOLS  = 4;
  localparam int DEF_QUOTA     = 8168;
  localparam int DEF_GHYST     = 120;

  localparam logic [ADDR_W-1:0] ADDR_QUOTA = 6'h20;
  localparam logic [ADDR_W-1:0] ADDR_GHYST = 6'h21;
  localparam logic [ADDR_W-1:0] ADDR_MODE  = 6'h22;

  typedef struct packed {
    logic [POOLS-1:0]  inc;
    logic [POOLS-1:0]  dec;
    logic              incTotal;
    logic              decTotal;
    logic              errSet;
    logic              wrLimit;
    logic              wrHyst;
    logic              wrQuota;
    logic              wrGHyst;
    logic              wrMode;
    logic [POOL_W-1:0] wrIdx;
    logic [DATA_W-1:0] wrData;
  } strobe_t;
endpackage

// File: rtl/bp_pool_map.sv
module bp_pool_map
  import bp_pkg::*;
(
  input  logic [POOL_W-1:0] reqPool,
  input  logic              circuit,
  input  logic [MODE_W-1:0] modeCfg,
  output logic [POOL_W-1:0] tgtPool
);
  logic [IF_W-1:0]   iface;
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] effSlot;
  logic [1:0]        split;

  assign iface = reqPool[POOL_W-1:SLOT_W];
  assign slot  = reqPool[SLOT_W-1:0];
  assign split = modeCfg[{iface, 1'b0} +: 2];

  // R8 slot folding by split mode, R9 circuit traffic pinned to slot 0
  always_comb begin
    if (circuit) begin
      effSlot = '0;
    end else begin
      unique case (split)
        2'b00:   effSlot = '0;
        2'b01:   effSlot = {{(SLOT_W-1){1'b0}}, slot[0]};
        default: effSlot = slot;
      endcase
    end
  end

  assign tgtPool = {iface, effSlot};
endmodule

// File: rtl/bp_ctrl.sv
module bp_ctrl
  import bp_pkg::*;
(
  input  logic              allocValid,
  input  logic [POOL_W-1:0] allocPool,
  input  logic              allocCircuit,
  input  logic              freeValid,
  input  logic [POOL_W-1:0] freePool,
  input  logic              freeCircuit,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [MODE_W-1:0] modeCfg,
  input  logic [POOLS-1:0]  poolZero,
  input  logic [POOLS-1:0]  poolFull,
  output strobe_t           st
);
  logic [POOL_W-1:0] allocTgt;
  logic [POOL_W-1:0] freeTgt;
  logic              samePool;
  logic              allocOk;
  logic              freeOk;
  logic              freeBad;

  bp_pool_map u_mapAlloc (
    .reqPool (allocPool),
    .circuit (allocCircuit),
    .modeCfg (modeCfg),
    .tgtPool (allocTgt)
  );

  bp_pool_map u_mapFree (
    .reqPool (freePool),
    .circuit (freeCircuit),
    .modeCfg (modeCfg),
    .tgtPool (freeTgt)
  );

  // R10 same-pool events cancel; R11 free to an empty pool is dropped
  assign samePool = allocValid && freeValid && (allocTgt == freeTgt);
  assign allocOk  = allocValid && !samePool && !poolFull[allocTgt];
  assign freeOk   = freeValid && !samePool && !poolZero[freeTgt];
  assign freeBad  = freeValid && !samePool && poolZero[freeTgt];

  always_comb begin
    st          = '0;
    st.incTotal = allocOk;
    st.decTotal = freeOk;
    st.errSet   = freeBad;
    if (allocOk) st.inc[allocTgt] = 1'b1;
    if (freeOk)  st.dec[freeTgt]  = 1'b1;
    st.wrIdx    = regAddr[POOL_W-1:0];
    st.wrData   = regWrData;
    if (regWrEn) begin
      st.wrLimit = (regAddr[ADDR_W-1:POOL_W] == 2'b00);
      st.wrHyst  = (regAddr[ADDR_W-1:POOL_W] == 2'b01);
      st.wrQuota = (regAddr == ADDR_QUOTA);
      st.wrGHyst = (regAddr == ADDR_GHYST);
      st.wrMode  = (regAddr == ADDR_MODE);
    end
  end
endmodule

// File: rtl/bp_datapath.sv
module bp_datapath
  import bp_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      st,
  output logic [POOLS-1:0]             poolBp,
  output logic                         globalBp,
  output logic                         errFlag,
  output logic [POOLS-1:0]             poolZero,
  output logic [POOLS-1:0]             poolFull,
  output logic [MODE_W-1:0]            modeCfg,
  output logic [POOLS-1:0][CNT_W-1:0]  poolCnt,
  output logic [POOLS-1:0][CNT_W-1:0]  limitCfg,
  output logic [POOLS-1:0][CNT_W-1:0]  hystCfg,
  output logic [TOT_W-1:0]             totalCnt,
  output logic [TOT_W-1:0]             quotaCfg,
  output logic [TOT_W-1:0]             gHystCfg
);
  for (genvar p = 0; p < POOLS; p++) begin : g_pool
    localparam logic [CNT_W-1:0] HYST_RST =
      (p < DEF_LO_POOLS) ? CNT_W'(DEF_HYST_LO) : CNT_W'(DEF_HYST_HI);
    logic overLimit;
    logic atRelease;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        limitCfg[p] <= CNT_W'(DEF_LIMIT);
        hystCfg[p]  <= HYST_RST;
      end else begin
        if (st.wrLimit && st.wrIdx == POOL_W'(p)) limitCfg[p] <= st.wrData[CNT_W-1:0];
        if (st.wrHyst  && st.wrIdx == POOL_W'(p)) hystCfg[p]  <= st.wrData[CNT_W-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)          poolCnt[p] <= '0;
      else if (st.inc[p]) poolCnt[p] <= poolCnt[p] + 1'b1;
      else if (st.dec[p]) poolCnt[p] <= poolCnt[p] - 1'b1;
    end

    assign overLimit   = poolCnt[p] > limitCfg[p];
    assign atRelease   = ({1'b0, poolCnt[p]} + {1'b0, hystCfg[p]}) <= {1'b0, limitCfg[p]};
    assign poolZero[p] = (poolCnt[p] == '0);
    assign poolFull[p] = (poolCnt[p] == '1);

    always_ff @(posedge clk) begin
      if (!rstN)                       poolBp[p] <= 1'b0;
      else if (!poolBp[p] && overLimit) poolBp[p] <= 1'b1;
      else if (poolBp[p] && atRelease)  poolBp[p] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quotaCfg <= TOT_W'(DEF_QUOTA);
      gHystCfg <= TOT_W'(DEF_GHYST);
      modeCfg  <= '0;
    end else begin
      if (st.wrQuota) quotaCfg <= st.wrData[TOT_W-1:0];
      if (st.wrGHyst) gHystCfg <= st.wrData[TOT_W-1:0];
      if (st.wrMode)  modeCfg  <= st.wrData[MODE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      totalCnt <= '0;
    end else begin
      unique case ({st.incTotal, st.decTotal})
        2'b10:   totalCnt <= totalCnt + 1'b1;
        2'b01:   totalCnt <= totalCnt - 1'b1;
        default: totalCnt <= totalCnt;
      endcase
    end
  end

  logic totOver;
  logic totRelease;
  assign totOver    = totalCnt > quotaCfg;
  assign totRelease = ({1'b0, totalCnt} + {1'b0, gHystCfg}) <= {1'b0, quotaCfg};

  always_ff @(posedge clk) begin
    if (!rstN)                      globalBp <= 1'b0;
    else if (!globalBp && totOver)  globalBp <= 1'b1;
    else if (globalBp && totRelease) globalBp <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          errFlag <= 1'b0;
    else if (st.errSet) errFlag <= 1'b1;
  end
endmodule

// File: rtl/buf_pool_bp.sv
module buf_pool_bp
  import bp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic [POOL_W-1:0] allocPool,
  input  logic              allocCircuit,
  input  logic              freeValid,
  input  logic [POOL_W-1:0] freePool,
  input  logic              freeCircuit,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [POOLS-1:0]  poolBp,
  output logic              globalBp,
  output logic              errFlag
);
  strobe_t                     st;
  logic [POOLS-1:0]            poolZero;
  logic [POOLS-1:0]            poolFull;
  logic [MODE_W-1:0]           modeCfg;
  logic [POOLS-1:0][CNT_W-1:0] poolCnt;
  logic [POOLS-1:0][CNT_W-1:0] limitCfg;
  logic [POOLS-1:0][CNT_W-1:0] hystCfg;
  logic [TOT_W-1:0]            totalCnt;
  logic [TOT_W-1:0]            quotaCfg;
  logic [TOT_W-1:0]            gHystCfg;

  bp_ctrl u_ctrl (
    .allocValid   (allocValid),
    .allocPool    (allocPool),
    .allocCircuit (allocCircuit),
    .freeValid    (freeValid),
    .freePool     (freePool),
    .freeCircuit  (freeCircuit),
    .regWrEn      (regWrEn),
    .regAddr      (regAddr),
    .regWrData    (regWrData),
    .modeCfg      (modeCfg),
    .poolZero     (poolZero),
    .poolFull     (poolFull),
    .st           (st)
  );

  bp_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .poolBp   (poolBp),
    .globalBp (globalBp),
    .errFlag  (errFlag),
    .poolZero (poolZero),
    .poolFull (poolFull),
    .modeCfg  (modeCfg),
    .poolCnt  (poolCnt),
    .limitCfg (limitCfg),
    .hystCfg  (hystCfg),
    .totalCnt (totalCnt),
    .quotaCfg (quotaCfg),
    .gHystCfg (gHystCfg)
  );
endmodule

// File: rtl/bp_checker.sv
module bp_checker
  import bp_pkg::*;
(
  input logic                        clk,
  input logic                        rstN,
  input logic [POOLS-1:0]            incVec,
  input logic [POOLS-1:0]            decVec,
  input logic                        errSet,
  input logic [POOLS-1:0][CNT_W-1:0] poolCnt,
  input logic [POOLS-1:0][CNT_W-1:0] limitCfg,
  input logic [POOLS-1:0][CNT_W-1:0] hystCfg,
  input logic [TOT_W-1:0]            totalCnt,
  input logic [TOT_W-1:0]            quotaCfg,
  input logic [TOT_W-1:0]            gHystCfg,
  input logic [POOLS-1:0]            poolBp,
  input logic                        globalBp,
  input logic                        errFlag
);
  function automatic logic [TOT_W-1:0] sumPools(input logic [POOLS-1:0][CNT_W-1:0] c);
    logic [TOT_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < POOLS; k++) acc = acc + TOT_W'(c[k]);
    return acc;
  endfunction

  for (genvar p = 0; p < POOLS; p++) begin : g_chk
    a_r2_rise_over_limit: assert property (@(posedge clk) disable iff (!rstN)
      $rose(poolBp[p]) |-> ($past(poolCnt[p]) > $past(limitCfg[p])));

    a_r5_fall_at_release: assert property (@(posedge clk) disable iff (!rstN)
      $fell(poolBp[p]) |->
        (({1'b0, $past(poolCnt[p])} + {1'b0, $past(hystCfg[p])}) <= {1'b0, $past(limitCfg[p])}));

    a_r4_single_step: assert property (@(posedge clk) disable iff (!rstN)
      (poolCnt[p] != $past(poolCnt[p])) |->
        ((poolCnt[p] == $past(poolCnt[p]) + 1'b1) || (poolCnt[p] == $past(poolCnt[p]) - 1'b1)));
  end

  a_r10_inc_onehot: assert property (@(posedge clk) disable iff (!rstN) $onehot0(incVec));
  a_r10_dec_onehot: assert property (@(posedge clk) disable iff (!rstN) $onehot0(decVec));

  a_r6_total_matches: assert property (@(posedge clk) disable iff (!rstN)
    totalCnt == sumPools(poolCnt));

  a_r6_global_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(globalBp) |-> ($past(totalCnt) > $past(quotaCfg)));

  a_r6_global_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(globalBp) |-> (({1'b0, $past(totalCnt)} + {1'b0, $past(gHystCfg)}) <= {1'b0, $past(quotaCfg)}));

  a_r11_err_set: assert property (@(posedge clk) disable iff (!rstN) errSet |=> errFlag);
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rstN) errFlag |=> errFlag);
endmodule

bind buf_pool_bp bp_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .incVec   (st.inc),
  .decVec   (st.dec),
  .errSet   (st.errSet),
  .poolCnt  (poolCnt),
  .limitCfg (limitCfg),
  .hystCfg  (hystCfg),
  .totalCnt (totalCnt),
  .quotaCfg (quotaCfg),
  .gHystCfg (gHystCfg),
  .poolBp   (poolBp),
  .globalBp (globalBp),
  .errFlag  (errFlag)
);

// File: tb/buf_pool_bp_tb.sv
`timescale 1ns/1ps
module buf_pool_bp_tb;
  import bp_pkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              allocValid = 1'b0;
  logic [POOL_W-1:0] allocPool = '0;
  logic              allocCircuit = 1'b0;
  logic              freeValid = 1'b0;
  logic [POOL_W-1:0] freePool = '0;
  logic              freeCircuit = 1'b0;
  logic              regWrEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [DATA_W-1:0] regWrData = '0;
  logic [POOLS-1:0]  poolBp;
  logic              globalBp;
  logic              errFlag;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  buf_pool_bp u_dut (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .allocPool(allocPool), .allocCircuit(allocCircuit),
    .freeValid(freeValid), .freePool(freePool), .freeCircuit(freeCircuit),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .poolBp(poolBp), .globalBp(globalBp), .errFlag(errFlag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; allocValid = 0; freeValid = 0; regWrEn = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic wrReg(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // Returns at the falling edge right after the sampling edge.
  task automatic allocEv(input logic [POOL_W-1:0] p, input logic c);
    @(negedge clk);
    allocValid = 1'b1; allocPool = p; allocCircuit = c;
    @(negedge clk);
    allocValid = 1'b0; allocCircuit = 1'b0;
  endtask

  task automatic freeEv(input logic [POOL_W-1:0] p, input logic c);
    @(negedge clk);
    freeValid = 1'b1; freePool = p; freeCircuit = c;
    @(negedge clk);
    freeValid = 1'b0; freeCircuit = 1'b0;
  endtask

  task automatic bothEv(input logic [POOL_W-1:0] ap, input logic [POOL_W-1:0] fp);
    @(negedge clk);
    allocValid = 1'b1; allocPool = ap; freeValid = 1'b1; freePool = fp;
    @(negedge clk);
    allocValid = 1'b0; freeValid = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic allocN(input logic [POOL_W-1:0] p, input int n);
    for (int k = 0; k < n; k++) allocEv(p, 1'b0);
    settle();
  endtask

  task automatic freeN(input logic [POOL_W-1:0] p, input int n);
    for (int k = 0; k < n; k++) freeEv(p, 1'b0);
    settle();
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 poolBp in reset", 32'(poolBp), 0);
    chk("R1 globalBp in reset", 32'(globalBp), 0);
    doReset();
    chk("R1 poolBp after reset", 32'(poolBp), 0);
    chk("R1 globalBp after reset", 32'(globalBp), 0);
    chk("R1 errFlag after reset", 32'(errFlag), 0);
  endtask

  task automatic t_limit_latency();
    doReset();
    wrReg(6'h00, 18'd3);               // R12 limit of pool 0
    allocN(4'd0, 3);
    chk("R2 count equal to limit", 32'(poolBp[0]), 0);
    allocEv(4'd0, 1'b0);
    chk("R3 output one cycle late", 32'(poolBp[0]), 0);
    settle();
    chk("R2 count above limit", 32'(poolBp[0]), 1);
  endtask

  task automatic t_inflight_hyst();
    doReset();
    wrReg(6'h00, 18'd3);
    wrReg(6'h10, 18'd1);               // R12 hysteresis of pool 0
    allocN(4'd0, 19);                  // limit + 16 in flight
    chk("R4 raised after in-flight", 32'(poolBp[0]), 1);
    freeN(4'd0, 16);                   // count 3
    chk("R5 held inside band", 32'(poolBp[0]), 1);
    freeEv(4'd0, 1'b0);                // count 2
    settle();
    chk("R5 released at limit-hyst", 32'(poolBp[0]), 0);
    chk("R4 no wrap error", 32'(errFlag), 0);
  endtask

  task automatic t_global();
    doReset();
    wrReg(ADDR_MODE, 18'hAA);
    wrReg(ADDR_QUOTA, 18'd5);
    wrReg(ADDR_GHYST, 18'd2);
    allocEv(4'd0, 0); allocEv(4'd5, 0); allocEv(4'd10, 0);
    allocEv(4'd15, 0); allocEv(4'd0, 0);
    settle();
    chk("R6 total equal quota", 32'(globalBp), 0);
    allocEv(4'd5, 0);
    settle();
    chk("R6 total above quota", 32'(globalBp), 1);
    chk("R6 no pool over", 32'(poolBp), 0);
    freeEv(4'd0, 0); freeEv(4'd5, 0);
    settle();
    chk("R6 held inside band", 32'(globalBp), 1);
    freeEv(4'd10, 0);
    settle();
    chk("R6 released", 32'(globalBp), 0);
  endtask

  task automatic t_defaults();
    doReset();
    allocN(4'd0, 494);
    chk("R7 pool0 limit 494 not exceeded", 32'(poolBp[0]), 0);
    allocN(4'd0, 1);
    chk("R7 pool0 over default limit", 32'(poolBp[0]), 1);
    freeN(4'd0, 6);
    chk("R7 pool0 hyst 6 held", 32'(poolBp[0]), 1);
    freeN(4'd0, 1);
    chk("R7 pool0 hyst 6 released", 32'(poolBp[0]), 0);
    allocN(4'd4, 495);
    chk("R7 pool4 over default limit", 32'(poolBp[4]), 1);
    freeN(4'd4, 40);
    chk("R7 pool4 hyst 40 held", 32'(poolBp[4]), 1);
    freeN(4'd4, 1);
    chk("R7 pool4 hyst 40 released", 32'(poolBp[4]), 0);
  endtask

  task automatic t_global_defaults();
    doReset();
    allocN(4'd0, 8168);
    chk("R7 quota 8168 not exceeded", 32'(globalBp), 0);
    allocN(4'd0, 1);
    chk("R7 over default quota", 32'(globalBp), 1);
    freeN(4'd0, 120);
    chk("R7 global hyst 120 held", 32'(globalBp), 1);
    freeN(4'd0, 1);
    chk("R7 global hyst 120 released", 32'(globalBp), 0);
  endtask

  task automatic t_mapping();
    doReset();
    for (int k = 0; k < POOLS; k++) wrReg(ADDR_W'(k), 18'd0);
    wrReg(ADDR_MODE, 18'h87);          // if0=11 if1=01 if2=00 if3=10
    allocEv(4'd11, 0); settle();
    chk("R8 one-pool mode slot 3 -> pool 8", 32'(poolBp), 32'h0100);
    allocEv(4'd7, 0); settle();
    chk("R8 two-pool mode slot 3 -> pool 5", 32'(poolBp), 32'h0120);
    allocEv(4'd14, 0); settle();
    chk("R8 four-pool mode code 10", 32'(poolBp), 32'h4120);
    allocEv(4'd2, 0); settle();
    chk("R8 four-pool mode code 11", 32'(poolBp), 32'h4124);
  endtask

  task automatic t_circuit();
    doReset();
    for (int k = 0; k < POOLS; k++) wrReg(ADDR_W'(k), 18'd0);
    wrReg(ADDR_MODE, 18'hAA);
    allocEv(4'd7, 1'b1); settle();
    chk("R9 circuit alloc -> pool 4", 32'(poolBp), 32'h0010);
    freeEv(4'd7, 1'b1); settle();
    chk("R9 circuit free hits pool 4", 32'(errFlag), 0);
  endtask

  task automatic t_same_cycle();
    doReset();
    wrReg(ADDR_MODE, 18'hAA);
    wrReg(6'h00, 18'd0); wrReg(6'h01, 18'd0);
    wrReg(6'h10, 18'd0); wrReg(6'h11, 18'd0);
    bothEv(4'd0, 4'd0); settle();
    chk("R10 netted at zero no bp", 32'(poolBp[1:0]), 0);
    chk("R10 netted at zero no error", 32'(errFlag), 0);
    allocEv(4'd0, 0); settle();
    bothEv(4'd0, 4'd0); settle();
    chk("R10 netted keeps count", 32'(poolBp[0]), 1);
    freeEv(4'd0, 0); settle();
    chk("R10 one free empties", 32'(poolBp[0]), 0);
    allocEv(4'd1, 0); settle();
    bothEv(4'd0, 4'd1); settle();
    chk("R10 different pools both apply", 32'(poolBp[1:0]), 32'h1);
  endtask

  task automatic t_free_zero();
    doReset();
    wrReg(ADDR_MODE, 18'hAA);
    wrReg(6'h02, 18'd0); wrReg(6'h12, 18'd0);
    wrReg(ADDR_QUOTA, 18'd0); wrReg(ADDR_GHYST, 18'd0);
    freeEv(4'd2, 0); settle();
    chk("R11 error set", 32'(errFlag), 1);
    chk("R11 pool untouched", 32'(poolBp[2]), 0);
    chk("R11 total untouched", 32'(globalBp), 0);
    allocEv(4'd2, 0); settle();
    chk("R11 count was zero", 32'(poolBp[2]), 1);
    chk("R11 total was zero", 32'(globalBp), 1);
    freeEv(4'd2, 0); settle();
    chk("R11 back to empty", 32'(poolBp[2]), 0);
    chk("R11 error sticky", 32'(errFlag), 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    t_reset();
    t_limit_latency();
    t_inflight_hyst();
    t_global();
    t_defaults();
    t_global_defaults();
    t_mapping();
    t_circuit();
    t_same_cycle();
    t_free_zero();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule